// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus and turns one request at a time into the bus cycles the device expects. A request names an operation (page read, page program, block erase or status read), one of four dies, a 24-bit address, a byte count and whether the 16-byte spare region takes part. The sequencer then drives the latch enables, the write and read strobes and the per-die chip enables, streams data bytes between the requester and the bus, waits on the ready/busy line, and ends each request with a one-cycle completion pulse carrying the error flags and the device status.

Strobe widths, the settle delay before ready/busy is trusted, and the longest allowed busy time per operation are parameters counted in system clocks. After a program or an erase the sequencer reads the device status on its own and reports its pass/fail bit. A small tracker refuses a program that would exceed the allowed number of partial programs to the same page.

Top module: `nand_seq`

## Requirements
- R1: Every command byte is driven on `io_o` with `cle_o` high and `ale_o` low, and is stable across the rising edge of `we_no_o`. Codes: read 0x00; program 0x80 then 0x10 after the data; erase 0x60 then 0xD0 after the address; status 0x70.
- R2: Each read, program and erase sends exactly three address cycles after its first command, with `ale_o` high and `cle_o` low, in the order address bits [7:0], [15:8], [23:16].
- R3: Each write or read strobe stays low for exactly `T_LO` clocks and then stays high for at least `T_HI` clocks; `we_no_o` and `re_no_o` are never low together and `cle_o` and `ale_o` are never high together.
- R4: A page read, after its address, waits `WB_CYC` clocks and then for `rb_i` high, and then gives one `re_no_o` pulse per byte; each byte on `io_i` at the end of its low phase appears on `rd_data_o` with a one-cycle `rd_valid_o`.
- R5: A page program sends its data bytes taken in turn from `wr_data_i` (each one announced by `wr_take_o`), the confirm command, waits for ready, issues a status read, and sets `status_fail_o` to bit 0 of the returned status (1 means failure).
- R6: A block erase sends the erase command, three address cycles and the confirm command with no data, waits for ready and then issues a status read.
- R7: A byte count of 0, or one above the page size, is replaced by the page size: 528 with the spare region, 512 without. `spare_off_o` is high for a request without the spare region and low for one with it.
- R8: Only the chip enable of the requested die (`ce_no_o[die]`) goes low, and only while a request is in progress; all are high when idle.
- R9: If ready/busy stays low longer than the limit of the current operation (`TO_READ`, `TO_PROG`, `TO_ERASE` clocks), the request ends with `err_timeout_o` set and no status read is issued.
- R10: The last programmed page, keyed by die and address bits [23:8], is tracked; a program that would be the (`NOP_MAX`+1)-th to it is refused with `err_nop_o` and no bus activity. A program to another page restarts the count, and any erase clears it.
- R11: A status request issues the status command and one read strobe and returns the byte on `status_o`; `done_o` is a single-cycle pulse and `req_ready_o` is high only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 0 read, 1 program, 2 erase, 3 status |
| req_die_i | input | DIE_W | Die number |
| req_addr_i | input | 24 | Column and row address |
| req_len_i | input | LEN_W | Byte count (0 means full page) |
| req_spare_i | input | 1 | Include spare region |
| req_ready_o | output | 1 | Idle, request accepted on valid |
| wr_data_i | input | 8 | Program data byte |
| wr_take_o | output | 1 | Current program byte taken |
| rd_data_o | output | 8 | Read data byte |
| rd_valid_o | output | 1 | Read byte strobe |
| done_o | output | 1 | Request finished |
| err_timeout_o | output | 1 | Busy exceeded its limit |
| err_nop_o | output | 1 | Program refused by partial-program limit |
| status_o | output | 8 | Last status byte |
| status_fail_o | output | 1 | Status reports failure |
| io_i | input | 8 | Bus data from device |
| io_o | output | 8 | Bus data to device |
| io_oe_o | output | 1 | Bus drive enable |
| rb_i | input | 1 | Ready/busy, low when busy |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no_o | output | 1 | Write strobe, active low |
| re_no_o | output | 1 | Read strobe, active low |
| spare_off_o | output | 1 | High to exclude spare region |
| ce_no_o | output | DIES | Per-die chip enable, active low |

## Verification
Each operation is driven against a bench device model on a different die and address so that the command bytes, the address byte order and the chip enable in use tell the four sequences apart. Reads use a position-dependent data pattern, so a dropped, repeated or shifted byte shows up, and full-page reads with and without the spare region separate the two length clamps. Status bytes with bit 0 clear and set separate a passing from a failing program, a held-low ready line separates the timeout path from the normal wait, and a run of programs to one page, then another page and an erase, separates refusal from the cases that restart or clear the count.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_STAT  = 2'd3
  } nseq_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDAT, S_CMD2, S_WAIT, S_RDAT, S_SCMD, S_SRD, S_FIN
  } nseq_st_e;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_PSET  = 8'h80;
  localparam logic [7:0] CMD_PGO   = 8'h10;
  localparam logic [7:0] CMD_ESET  = 8'h60;
  localparam logic [7:0] CMD_EGO   = 8'hD0;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam int         ADDR_W    = 24;

  function automatic logic [7:0] lead_cmd(nseq_op_e op);
    case (op)
      OP_PROG:  return CMD_PSET;
      OP_ERASE: return CMD_ESET;
      OP_STAT:  return CMD_STAT;
      default:  return CMD_READ;
    endcase
  endfunction

  function automatic logic [7:0] go_cmd(nseq_op_e op);
    return (op == OP_ERASE) ? CMD_EGO : CMD_PGO;
  endfunction

endpackage

// File: rtl/nseq_strobe.sv
module nseq_strobe #(
  parameter int LO = 3,
  parameter int HI = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic low_o,
  output logic sample_o,
  output logic done_o
);
  localparam int TOT = LO + HI;
  localparam int CW  = $clog2(TOT + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign low_o    = busy_q && (cnt_q < CW'(LO));
  assign sample_o = busy_q && (cnt_q == CW'(LO - 1));
  assign done_o   = busy_q && (cnt_q == CW'(TOT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nseq_wait.sv
module nseq_wait #(
  parameter int WB = 4,
  parameter int TW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rb_i,
  input  logic [TW-1:0] limit_i,
  output logic          ok_o,
  output logic          to_o
);
  logic [1:0]    sync_q;
  logic          act_q;
  logic [TW-1:0] cnt_q;

  // ready/busy is asynchronous open-drain: two-stage sync
  assign ok_o = act_q && (cnt_q >= TW'(WB)) && sync_q[1];
  assign to_o = act_q && !ok_o && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rb_i};
      if (start_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (act_q) begin
        if (ok_o || to_o) act_q <= 1'b0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nseq_nop.sv
module nseq_nop #(
  parameter int KW   = 18,
  parameter int NMAX = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [KW-1:0] key_i,
  input  logic          upd_i,
  input  logic          clr_i,
  output logic          full_o
);
  localparam int NW = $clog2(NMAX + 1);

  logic          vld_q;
  logic [KW-1:0] key_q;
  logic [NW-1:0] cnt_q;
  logic          hit;

  assign hit    = vld_q && (key_q == key_i);
  assign full_o = hit && (cnt_q >= NW'(NMAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      key_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else if (upd_i) begin
      if (hit) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        vld_q <= 1'b1;
        key_q <= key_i;
        cnt_q <= NW'(1);
      end
    end
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nseq_pkg::*;
#(
  parameter int DIES       = 4,
  parameter int PAGE_MAIN  = 512,
  parameter int PAGE_SPARE = 16,
  parameter int T_LO       = 3,
  parameter int T_HI       = 2,
  parameter int WB_CYC     = 4,
  parameter int TO_READ    = 500,
  parameter int TO_PROG    = 75000,
  parameter int TO_ERASE   = 500000,
  parameter int NOP_MAX    = 10,
  localparam int DIE_W     = (DIES > 1) ? $clog2(DIES) : 1,
  localparam int LEN_W     = $clog2(PAGE_MAIN + PAGE_SPARE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [DIE_W-1:0] req_die_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             req_spare_i,
  output logic             req_ready_o,
  input  logic [7:0]       wr_data_i,
  output logic             wr_take_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_timeout_o,
  output logic             err_nop_o,
  output logic [7:0]       status_o,
  output logic             status_fail_o,
  input  logic [7:0]       io_i,
  output logic [7:0]       io_o,
  output logic             io_oe_o,
  input  logic             rb_i,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_no_o,
  output logic             re_no_o,
  output logic             spare_off_o,
  output logic [DIES-1:0]  ce_no_o
);
  localparam int PAGE_FULL = PAGE_MAIN + PAGE_SPARE;
  localparam int TO_MAX    = (TO_ERASE > TO_PROG) ? ((TO_ERASE > TO_READ) ? TO_ERASE : TO_READ)
                                                  : ((TO_PROG > TO_READ) ? TO_PROG : TO_READ);
  localparam int TW        = $clog2(((TO_MAX > WB_CYC) ? TO_MAX : WB_CYC) + 1);
  localparam int KW        = DIE_W + 16;

  nseq_st_e          st_q;
  nseq_op_e          op_q, op_in;
  logic              kick_q;
  logic [DIE_W-1:0]  die_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, len_in, lim_in, idx_q;
  logic              spare_q;
  logic [7:0]        wbyte_q, rd_data_q, stat_q;
  logic              rd_vld_q, err_to_q, err_nop_q;

  logic accept, is_prog, nop_full, nop_upd, nop_rej, nop_clr;
  logic bus_st, wr_st, rd_st, ce_act;
  logic s_low, s_sample, s_done, w_ok, w_to;
  logic [TW-1:0] w_limit;

  assign op_in   = nseq_op_e'(req_op_i);
  assign accept  = (st_q == S_IDLE) && req_valid_i;
  assign is_prog = accept && (op_in == OP_PROG);
  assign nop_rej = is_prog && nop_full;
  assign nop_upd = is_prog && !nop_full;
  assign nop_clr = accept && (op_in == OP_ERASE);

  assign lim_in = req_spare_i ? LEN_W'(PAGE_FULL) : LEN_W'(PAGE_MAIN);
  assign len_in = ((req_len_i == '0) || (req_len_i > lim_in)) ? lim_in : req_len_i;

  assign wr_st  = (st_q == S_CMD1) || (st_q == S_ADDR) || (st_q == S_WDAT) ||
                  (st_q == S_CMD2) || (st_q == S_SCMD);
  assign rd_st  = (st_q == S_RDAT) || (st_q == S_SRD);
  assign bus_st = wr_st || rd_st;
  assign ce_act = (st_q != S_IDLE) && (st_q != S_FIN);

  always_comb begin
    case (op_q)
      OP_READ: w_limit = TW'(TO_READ);
      OP_PROG: w_limit = TW'(TO_PROG);
      default: w_limit = TW'(TO_ERASE);
    endcase
  end

  nseq_strobe #(.LO(T_LO), .HI(T_HI)) u_strobe (
    .clk_i, .rst_ni, .start_i(kick_q && bus_st),
    .low_o(s_low), .sample_o(s_sample), .done_o(s_done)
  );

  nseq_wait #(.WB(WB_CYC), .TW(TW)) u_wait (
    .clk_i, .rst_ni, .start_i(kick_q && (st_q == S_WAIT)), .rb_i,
    .limit_i(w_limit), .ok_o(w_ok), .to_o(w_to)
  );

  nseq_nop #(.KW(KW), .NMAX(NOP_MAX)) u_nop (
    .clk_i, .rst_ni, .key_i({req_die_i, req_addr_i[23:8]}),
    .upd_i(nop_upd), .clr_i(nop_clr), .full_o(nop_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      op_q      <= OP_READ;
      kick_q    <= 1'b0;
      die_q     <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      spare_q   <= 1'b0;
      idx_q     <= '0;
      wbyte_q   <= '0;
      rd_data_q <= '0;
      rd_vld_q  <= 1'b0;
      stat_q    <= '0;
      err_to_q  <= 1'b0;
      err_nop_q <= 1'b0;
    end else begin
      kick_q   <= 1'b0;
      rd_vld_q <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          op_q      <= op_in;
          die_q     <= req_die_i;
          addr_q    <= req_addr_i;
          len_q     <= len_in;
          spare_q   <= req_spare_i;
          idx_q     <= '0;
          stat_q    <= '0;
          err_to_q  <= 1'b0;
          err_nop_q <= nop_rej;
          if (nop_rej) begin
            st_q <= S_FIN;
          end else begin
            st_q   <= (op_in == OP_STAT) ? S_SCMD : S_CMD1;
            kick_q <= 1'b1;
          end
        end
        S_CMD1: if (s_done) begin
          st_q   <= S_ADDR;
          idx_q  <= '0;
          kick_q <= 1'b1;
        end
        S_ADDR: if (s_done) begin
          kick_q <= 1'b1;
          if (idx_q == LEN_W'(2)) begin
            idx_q <= '0;
            st_q  <= (op_q == OP_PROG) ? S_WDAT : (op_q == OP_ERASE) ? S_CMD2 : S_WAIT;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_WDAT: begin
          if (kick_q) wbyte_q <= wr_data_i;
          if (s_done) begin
            kick_q <= 1'b1;
            if (idx_q == len_q - 1'b1) st_q <= S_CMD2;
            else                       idx_q <= idx_q + 1'b1;
          end
        end
        S_CMD2: if (s_done) begin
          st_q   <= S_WAIT;
          kick_q <= 1'b1;
        end
        S_WAIT: begin
          if (w_ok) begin
            kick_q <= 1'b1;
            idx_q  <= '0;
            st_q   <= (op_q == OP_READ) ? S_RDAT : S_SCMD;
          end else if (w_to) begin
            err_to_q <= 1'b1;
            st_q     <= S_FIN;
          end
        end
        S_RDAT: begin
          if (s_sample) begin
            rd_data_q <= io_i;
            rd_vld_q  <= 1'b1;
          end
          if (s_done) begin
            if (idx_q == len_q - 1'b1) begin
              st_q <= S_FIN;
            end else begin
              idx_q  <= idx_q + 1'b1;
              kick_q <= 1'b1;
            end
          end
        end
        S_SCMD: if (s_done) begin
          st_q   <= S_SRD;
          kick_q <= 1'b1;
        end
        S_SRD: begin
          if (s_sample) stat_q <= io_i;
          if (s_done)   st_q   <= S_FIN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_CMD1:  io_o = lead_cmd(op_q);
      S_CMD2:  io_o = go_cmd(op_q);
      S_SCMD:  io_o = CMD_STAT;
      S_ADDR:  io_o = (idx_q[1:0] == 2'd0) ? addr_q[7:0] :
                      (idx_q[1:0] == 2'd1) ? addr_q[15:8] : addr_q[23:16];
      S_WDAT:  io_o = wbyte_q;
      default: io_o = 8'h00;
    endcase
  end

  for (genvar g = 0; g < DIES; g++) begin : g_ce
    assign ce_no_o[g] = !(ce_act && (die_q == DIE_W'(g)));
  end

  assign req_ready_o   = (st_q == S_IDLE);
  assign done_o        = (st_q == S_FIN);
  assign wr_take_o     = kick_q && (st_q == S_WDAT);
  assign rd_data_o     = rd_data_q;
  assign rd_valid_o    = rd_vld_q;
  assign err_timeout_o = err_to_q;
  assign err_nop_o     = err_nop_q;
  assign status_o      = stat_q;
  assign status_fail_o = stat_q[0];
  assign io_oe_o       = wr_st;
  assign cle_o         = (st_q == S_CMD1) || (st_q == S_CMD2) || (st_q == S_SCMD);
  assign ale_o         = (st_q == S_ADDR);
  assign we_no_o       = !(s_low && wr_st);
  assign re_no_o       = !(s_low && rd_st);
  assign spare_off_o   = !spare_q;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int DIES = 4,
  parameter int T_LO = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            done_o,
  input logic [7:0]      io_o,
  input logic            io_oe_o,
  input logic            cle_o,
  input logic            ale_o,
  input logic            we_no_o,
  input logic            re_no_o,
  input logic [DIES-1:0] ce_no_o
);
  logic [7:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     lo_cnt <= '0;
    else if (we_no_o && re_no_o)     lo_cnt <= '0;
    else if (lo_cnt != 8'hFF)        lo_cnt <= lo_cnt + 1'b1;
  end

  assert_one_ce_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ce_no_o) <= 1);
  assert_idle_ce_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (&ce_no_o));
  assert_latch_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no_o && !re_no_o));
  assert_we_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no_o) |-> ($stable(io_o) && $stable(cle_o) && $stable(ale_o)));
  assert_we_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no_o |-> io_oe_o);
  assert_low_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(we_no_o) || $rose(re_no_o)) |-> (lo_cnt == 8'(T_LO)));
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind nand_seq nand_seq_chk #(.DIES(DIES), .T_LO(T_LO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .done_o(done_o),
  .io_o(io_o), .io_oe_o(io_oe_o), .cle_o(cle_o), .ale_o(ale_o),
  .we_no_o(we_no_o), .re_no_o(re_no_o), .ce_no_o(ce_no_o)
);

// File: tb/sim_nand_seq.sv
module sim_nand_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_LO = 2, T_HI = 1, BUSY_LEN = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_spare_i = 1'b0;
  logic [1:0] req_op_i = '0, req_die_i = '0;
  logic [23:0] req_addr_i = '0;
  logic [9:0] req_len_i = '0;
  logic [7:0] wr_data_i, io_i = 8'h00;
  logic rb_i;
  logic req_ready_o, wr_take_o, rd_valid_o, done_o, err_timeout_o, err_nop_o;
  logic status_fail_o, io_oe_o, cle_o, ale_o, we_no_o, re_no_o, spare_off_o;
  logic [7:0] rd_data_o, status_o, io_o;
  logic [3:0] ce_no_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nand_seq #(.T_LO(T_LO), .T_HI(T_HI), .WB_CYC(3), .TO_READ(30), .TO_PROG(40),
             .TO_ERASE(60), .NOP_MAX(10)) u0 (.*);

  int nvec = 0, nbad = 0;
  // device model state
  int lk[0:63]; logic [7:0] lb[0:63]; int ln = 0;
  logic [7:0] rd_buf[0:599]; int rd_n = 0, re_n = 0;
  int wr_idx = 0; bit wr_pend = 0;
  int busy_cnt = 0; bit stuck = 0; bit stat_mode = 0; int rd_idx = 0;
  logic [7:0] last_cmd = 8'hFF; int acnt = 0; logic [7:0] stat_byte = 8'hE0;
  bit prev_we = 1, prev_re = 1; int lo_w = 0, hi_w = 0, min_lo = 999, min_hi = 999;
  logic [3:0] ce_mask = '0;
  // results captured at done
  bit r_to, r_nop, r_fail; logic [7:0] r_stat; bit r_spoff;

  assign wr_data_i = 8'(wr_idx * 3 + 1);
  assign rb_i = !(stuck || busy_cnt != 0);

  function automatic logic [7:0] rd_pat(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  always @(negedge clk_i) begin
    if (wr_pend) begin wr_idx++; wr_pend = 0; end
    if (wr_take_o) wr_pend = 1;
    if (busy_cnt > 0) busy_cnt--;
    if (!prev_we && we_no_o) begin
      if (ln < 64) begin lk[ln] = cle_o ? 1 : ale_o ? 2 : 3; lb[ln] = io_o; end
      ln++;
      if (cle_o) begin
        last_cmd = io_o; acnt = 0; rd_idx = 0;
        stat_mode = (io_o == 8'h70);
        if (io_o == 8'h10 || io_o == 8'hD0) busy_cnt = BUSY_LEN;
      end else if (ale_o) begin
        acnt++;
        if (last_cmd == 8'h00 && acnt == 3) busy_cnt = BUSY_LEN;
      end
    end
    if (prev_re && !re_no_o) begin
      io_i = stat_mode ? stat_byte : rd_pat(rd_idx);
      rd_idx++; re_n++;
    end
    if (!we_no_o || !re_no_o) begin
      if (hi_w > 0 && hi_w < min_hi) min_hi = hi_w;
      hi_w = 0; lo_w++;
    end else begin
      if (lo_w > 0 && lo_w < min_lo) min_lo = lo_w;
      lo_w = 0; hi_w++;
    end
    prev_we = we_no_o; prev_re = re_no_o;
    if (rd_valid_o) begin if (rd_n < 600) rd_buf[rd_n] = rd_data_o; rd_n++; end
    ce_mask = ce_mask | ~ce_no_o;
  end

  task automatic chk(string req, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_log(string req, int i, int kind, int b);
    chk(req, $sformatf("bus cycle %0d kind", i), lk[i], kind);
    chk(req, $sformatf("bus cycle %0d byte", i), lb[i], b);
  endtask

  task automatic run_op(int op, int die, int addr, int len, bit spare);
    int guard;
    ln = 0; rd_n = 0; re_n = 0; ce_mask = '0; min_lo = 999; min_hi = 999;
    @(negedge clk_i);
    req_valid_i = 1; req_op_i = 2'(op); req_die_i = 2'(die);
    req_addr_i = 24'(addr); req_len_i = 10'(len); req_spare_i = spare;
    @(negedge clk_i);
    req_valid_i = 0;
    guard = 0;
    while (!done_o && guard < 20000) begin @(negedge clk_i); guard++; end
    if (!done_o) chk("R11", "done never seen", 0, 1);
    r_to = err_timeout_o; r_nop = err_nop_o; r_fail = status_fail_o;
    r_stat = status_o; r_spoff = spare_off_o;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R11", "ready after reset", req_ready_o, 1);
    chk("R8", "ce after reset", ce_no_o, 4'hF);
    chk("R3", "strobes after reset", {we_no_o, re_no_o, cle_o, ale_o}, 4'b1100);
    chk("R11", "done after reset", done_o, 0);
  endtask

  task automatic t_read();
    bit bad = 0;
    run_op(0, 1, 24'h123456, 5, 1);
    chk("R1", "read cycles", ln, 4);
    chk_log("R1", 0, 1, 8'h00);
    chk_log("R2", 1, 2, 8'h56);
    chk_log("R2", 2, 2, 8'h34);
    chk_log("R2", 3, 2, 8'h12);
    chk("R4", "read bytes", rd_n, 5);
    for (int i = 0; i < 5; i++) if (rd_buf[i] != rd_pat(i)) bad = 1;
    chk("R4", "read data pattern", bad, 0);
    chk("R8", "die 1 enable", ce_mask, 4'b0010);
    chk("R3", "min low width", min_lo, T_LO);
    chk("R3", "min high width ok", min_hi >= T_HI, 1);
    chk("R7", "spare selected", r_spoff, 0);
    chk("R9", "no timeout", r_to, 0);
  endtask

  task automatic t_prog(bit fail);
    int base;
    stat_byte = fail ? 8'hE1 : 8'hE0;
    base = wr_idx;
    run_op(1, 2, 24'h00AB10, 4, 0);
    chk("R5", "program cycles", ln, 10);
    chk_log("R1", 0, 1, 8'h80);
    chk_log("R2", 1, 2, 8'h10);
    chk_log("R2", 2, 2, 8'hAB);
    chk_log("R2", 3, 2, 8'h00);
    for (int i = 0; i < 4; i++) chk_log("R5", 4 + i, 3, 8'((base + i) * 3 + 1));
    chk_log("R1", 8, 1, 8'h10);
    chk_log("R5", 9, 1, 8'h70);
    chk("R5", "status fail bit", r_fail, fail);
    chk("R8", "die 2 enable", ce_mask, 4'b0100);
    chk("R7", "spare excluded", r_spoff, 1);
    stat_byte = 8'hE0;
  endtask

  task automatic t_erase();
    run_op(2, 3, 24'h3F4200, 0, 0);
    chk("R6", "erase cycles", ln, 6);
    chk_log("R6", 0, 1, 8'h60);
    chk_log("R2", 1, 2, 8'h00);
    chk_log("R2", 2, 2, 8'h42);
    chk_log("R2", 3, 2, 8'h3F);
    chk_log("R6", 4, 1, 8'hD0);
    chk_log("R6", 5, 1, 8'h70);
    chk("R6", "one status strobe", re_n, 1);
    chk("R8", "die 3 enable", ce_mask, 4'b1000);
  endtask

  task automatic t_status();
    stat_byte = 8'hC1;
    run_op(3, 0, 0, 0, 0);
    chk("R11", "status cycles", ln, 1);
    chk_log("R11", 0, 1, 8'h70);
    chk("R11", "status strobes", re_n, 1);
    chk("R11", "status byte", r_stat, 8'hC1);
    chk("R11", "no read data", rd_n, 0);
    stat_byte = 8'hE0;
  endtask

  task automatic t_timeout();
    stuck = 1;
    run_op(2, 0, 24'h000100, 0, 0);
    chk("R9", "timeout flag", r_to, 1);
    chk("R9", "stops after confirm", ln, 5);
    chk("R9", "no status read", re_n, 0);
    stuck = 0;
  endtask

  task automatic t_clamp();
    bit bad = 0;
    run_op(0, 0, 24'h000200, 0, 0);
    chk("R7", "zero length main page", rd_n, 512);
    for (int i = 0; i < 512; i++) if (rd_buf[i] != rd_pat(i)) bad = 1;
    chk("R4", "full page pattern", bad, 0);
    run_op(0, 0, 24'h000200, 600, 1);
    chk("R7", "over length with spare", rd_n, 528);
    run_op(0, 0, 24'h000200, 515, 0);
    chk("R7", "over length without spare", rd_n, 512);
  endtask

  task automatic t_nop();
    int errs = 0;
    run_op(2, 0, 24'h004400, 0, 0);
    for (int i = 0; i < 10; i++) begin
      run_op(1, 0, 24'h004400, 1, 0);
      errs += r_nop;
    end
    chk("R10", "ten programs accepted", errs, 0);
    run_op(1, 0, 24'h004400, 1, 0);
    chk("R10", "eleventh refused", r_nop, 1);
    chk("R10", "no bus cycles on refusal", ln, 0);
    chk("R10", "no enable on refusal", ce_mask, 0);
    run_op(1, 0, 24'h004500, 1, 0);
    chk("R10", "other page accepted", r_nop, 0);
    run_op(1, 0, 24'h004400, 1, 0);
    chk("R10", "count restarted", r_nop, 0);
    for (int i = 0; i < 9; i++) run_op(1, 0, 24'h004400, 1, 0);
    run_op(2, 0, 24'h004400, 0, 0);
    run_op(1, 0, 24'h004400, 1, 0);
    chk("R10", "erase clears count", r_nop, 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_read();
    t_prog(0);
    t_prog(1);
    t_erase();
    t_status();
    t_timeout();
    t_clamp();
    t_nop();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    nvec++; nbad++;
    $display("FAIL R11 watchdog expired: actual running expected finished");
    report();
    $finish;
  end
endmodule